// File: doc/BRIEF.md
# Cascaded Interrupt Status Encoder

This block sits between the request lines of three interrupt groups (critical, main and peripheral) and the interrupt handler. It gates the main and peripheral requests with two mask registers, in which a 1 disables a source. It picks the lowest-numbered enabled pending source in each group and packs the three results into one status word. Each result has its own valid flag. Software reads the word and services the critical field first, then the main field, then the peripheral field.

Two code slots are taken from the peripheral group. Enabled peripheral sources numbered below `PER_HI_COUNT` appear as critical code 2. All other enabled peripheral sources appear as main code 4. When software sees either code, it goes on to the peripheral field. Peripheral code 0 is the cascaded DMA request, which software resolves from a separate pending register. The status word and the interrupt output are combinational. The mask registers are written through a small synchronous write port and read back combinationally.

Top module: `irq_status_enc`

## Requirements
- R1: After reset the main mask reads 0x00010FFF and the peripheral mask reads 0x7FFFFC00.
- R2: A write with `mask_sel_i`=0 loads the main mask and one with `mask_sel_i`=1 loads the peripheral mask on the next clock edge. Only main bits 16:0 and peripheral bits 31:8 (with `NUM_PER`=24) are stored; all other bits read 0. `mask_rdata_o` shows the register picked by `mask_sel_i`.
- R3: Main source n (0..16) is disabled while main mask bit 16−n is 1.
- R4: Peripheral source n is disabled while peripheral mask bit 31−n is 1.
- R5: Status bit 10 flags critical activity and bits 9:8 give the lowest-numbered pending critical source. Critical sources have no mask, and `crit_req_i[2]` is ignored.
- R6: Any enabled pending peripheral source below `PER_HI_COUNT` (4) makes critical code 2 pending.
- R7: Status bit 21 flags main activity and bits 20:16 give the lowest-numbered enabled pending main source. `main_req_i[4]` is ignored.
- R8: Any enabled pending peripheral source at or above `PER_HI_COUNT` makes main code 4 pending. Main mask bit 12 still gates it.
- R9: Status bit 29 flags peripheral activity and bits 28:24 give the lowest-numbered enabled pending peripheral source.
- R10: All status bits outside 29:24, 21:16 and 10:8 read 0.
- R11: `irq_o` is 1 exactly when status bit 10, 21 or 29 is 1.
- R12: The status word follows the request inputs within the same cycle, and a mask write changes it from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crit_req_i | input | 4 | Critical group requests (bit 2 unused) |
| main_req_i | input | 17 | Main group requests (bit 4 unused) |
| per_req_i | input | NUM_PER | Peripheral group requests, bit 0 is the DMA cascade |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_sel_i | input | 1 | 0 selects main mask, 1 selects peripheral mask |
| mask_wdata_i | input | 32 | Mask write data |
| mask_rdata_o | output | 32 | Selected mask register value |
| status_o | output | 32 | Encoded status word |
| irq_o | output | 1 | Any group valid |

## Verification
The only internal state is the two mask registers. A wrong bit in either one shows at `mask_rdata_o` in the first cycle after the write. It also shows in the status word as soon as the matching source is asserted. A mask bit mapped to the wrong source shows up as a wrong code in the same cycle. The same is true of a wrong code in either redirect slot. The bench checks every cycle, with directed patterns first and random requests and writes after them. A fault therefore shows within a cycle of the first stimulus that exposes it.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int CRIT_FLAG_BIT = 10;
  localparam int CRIT_CODE_LSB = 8;
  localparam int MAIN_FLAG_BIT = 21;
  localparam int MAIN_CODE_LSB = 16;
  localparam int PER_FLAG_BIT  = 29;
  localparam int PER_CODE_LSB  = 24;
  localparam int CRIT_HP_SLOT  = 2;
  localparam int MAIN_LP_SLOT  = 4;
  localparam logic [31:0] MAIN_MASK_RST = 32'h0001_0FFF;
  localparam logic [31:0] PER_MASK_RST  = 32'h7FFF_FC00;
  localparam logic [31:0] STATUS_USED   = 32'h3F3F_0700;

  typedef enum logic {
    SEL_MAIN = 1'b0,
    SEL_PER  = 1'b1
  } mask_sel_e;
endpackage

// File: rtl/prio_enc.sv
module prio_enc #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  // scan downwards so the lowest set bit is written last
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/mask_regs.sv
module mask_regs
  import irq_stat_pkg::*;
#(
  parameter int NUM_MAIN = 17,
  parameter int NUM_PER  = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                sel_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_MAIN-1:0] main_dis_o,
  output logic [NUM_PER-1:0]  per_dis_o
);
  localparam logic [31:0] MAIN_KEEP = 32'((64'd1 << NUM_MAIN) - 64'd1);
  localparam logic [31:0] PER_KEEP  = ~32'((64'd1 << (32 - NUM_PER)) - 64'd1);

  logic [31:0] main_q, per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= MAIN_MASK_RST & MAIN_KEEP;
      per_q  <= PER_MASK_RST & PER_KEEP;
    end else if (wr_i) begin
      if (sel_i == SEL_PER) per_q  <= wdata_i & PER_KEEP;
      else                  main_q <= wdata_i & MAIN_KEEP;
    end
  end

  assign rdata_o = (sel_i == SEL_PER) ? per_q : main_q;

  // register bits are stored in reverse source order
  for (genvar n = 0; n < NUM_MAIN; n++) begin : g_main_map
    assign main_dis_o[n] = main_q[NUM_MAIN-1-n];
  end
  for (genvar n = 0; n < NUM_PER; n++) begin : g_per_map
    assign per_dis_o[n] = per_q[31-n];
  end
endmodule

// File: rtl/irq_status_enc.sv
module irq_status_enc
  import irq_stat_pkg::*;
#(
  parameter int NUM_PER      = 24,
  parameter int PER_HI_COUNT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [3:0]         crit_req_i,
  input  logic [16:0]        main_req_i,
  input  logic [NUM_PER-1:0] per_req_i,
  input  logic               mask_wr_i,
  input  logic               mask_sel_i,
  input  logic [31:0]        mask_wdata_i,
  output logic [31:0]        mask_rdata_o,
  output logic [31:0]        status_o,
  output logic               irq_o
);
  localparam int NUM_CRIT = 4;
  localparam int NUM_MAIN = 17;
  localparam int CRIT_W   = 2;
  localparam int CODE_W   = 5;
  localparam logic [NUM_CRIT-1:0] CRIT_SLOT = NUM_CRIT'(1) << CRIT_HP_SLOT;
  localparam logic [NUM_MAIN-1:0] MAIN_SLOT = NUM_MAIN'(1) << MAIN_LP_SLOT;

  logic [NUM_MAIN-1:0] main_dis;
  logic [NUM_PER-1:0]  per_dis, per_act;
  logic [NUM_CRIT-1:0] crit_eff;
  logic [NUM_MAIN-1:0] main_eff;
  logic                hi_any, lo_any;
  logic                crit_v, main_v, per_v;
  logic [CRIT_W-1:0]   crit_code;
  logic [CODE_W-1:0]   main_code, per_code;

  mask_regs #(.NUM_MAIN(NUM_MAIN), .NUM_PER(NUM_PER)) u_masks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (mask_wr_i),
    .sel_i      (mask_sel_i),
    .wdata_i    (mask_wdata_i),
    .rdata_o    (mask_rdata_o),
    .main_dis_o (main_dis),
    .per_dis_o  (per_dis)
  );

  assign per_act = per_req_i & ~per_dis;
  assign hi_any  = |per_act[PER_HI_COUNT-1:0];
  assign lo_any  = |per_act[NUM_PER-1:PER_HI_COUNT];

  // reserved slots carry peripheral activity instead of the raw request bit
  assign crit_eff = (crit_req_i & ~CRIT_SLOT) | (hi_any ? CRIT_SLOT : '0);
  assign main_eff = ((main_req_i & ~MAIN_SLOT) | (lo_any ? MAIN_SLOT : '0)) & ~main_dis;

  prio_enc #(.N(NUM_CRIT), .W(CRIT_W)) u_crit_enc (
    .req_i(crit_eff), .valid_o(crit_v), .idx_o(crit_code));
  prio_enc #(.N(NUM_MAIN), .W(CODE_W)) u_main_enc (
    .req_i(main_eff), .valid_o(main_v), .idx_o(main_code));
  prio_enc #(.N(NUM_PER), .W(CODE_W)) u_per_enc (
    .req_i(per_act), .valid_o(per_v), .idx_o(per_code));

  always_comb begin
    status_o = '0;
    status_o[CRIT_FLAG_BIT] = crit_v;
    status_o[CRIT_CODE_LSB +: CRIT_W] = crit_code;
    status_o[MAIN_FLAG_BIT] = main_v;
    status_o[MAIN_CODE_LSB +: CODE_W] = main_code;
    status_o[PER_FLAG_BIT] = per_v;
    status_o[PER_CODE_LSB +: CODE_W] = per_code;
  end

  assign irq_o = crit_v | main_v | per_v;

  p_irq_any_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status_o[CRIT_FLAG_BIT] | status_o[MAIN_FLAG_BIT] | status_o[PER_FLAG_BIT]));
  p_unused_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~STATUS_USED) == 32'd0);
  p_per_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[PER_FLAG_BIT] |-> per_req_i[status_o[PER_CODE_LSB +: CODE_W]]);
  p_hi_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_any |-> (status_o[CRIT_FLAG_BIT] && status_o[CRIT_CODE_LSB +: CRIT_W] <= CRIT_W'(CRIT_HP_SLOT)));
  p_lo_slot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_any && !main_dis[MAIN_LP_SLOT]) |->
      (status_o[MAIN_FLAG_BIT] && status_o[MAIN_CODE_LSB +: CODE_W] <= CODE_W'(MAIN_LP_SLOT)));
  p_main_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && mask_sel_i == SEL_MAIN) |=> main_dis[0] == $past(mask_wdata_i[16]));
endmodule

// File: tb/irq_status_enc_tb.sv
module irq_status_enc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  crit = '0;
  logic [16:0] mreq = '0;
  logic [23:0] preq = '0;
  logic        wr = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, status;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mm = 32'h0001_0FFF, pm = 32'h7FFF_FC00;

  always #5 clk = ~clk;

  irq_status_enc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .crit_req_i(crit), .main_req_i(mreq),
    .per_req_i(preq), .mask_wr_i(wr), .mask_sel_i(sel), .mask_wdata_i(wdata),
    .mask_rdata_o(rdata), .status_o(status), .irq_o(irq));

  function automatic logic [31:0] model(input logic [3:0] c, input logic [16:0] m,
                                        input logic [23:0] p, input logic [31:0] mmask,
                                        input logic [31:0] pmask);
    logic [31:0] s = '0;
    int pc = -1, cc = -1, mc = -1;
    bit hi = 0, lo = 0, pend;
    for (int n = 0; n < 24; n++)
      if (p[n] && !pmask[31-n]) begin
        if (pc < 0) pc = n;
        if (n < 4) hi = 1; else lo = 1;
      end
    for (int n = 0; n < 4; n++) begin
      pend = (n == 2) ? hi : c[n];
      if (pend && cc < 0) cc = n;
    end
    for (int n = 0; n < 17; n++) begin
      pend = ((n == 4) ? lo : m[n]) && !mmask[16-n];
      if (pend && mc < 0) mc = n;
    end
    if (cc >= 0) begin s[10] = 1; s[9:8] = 2'(cc); end
    if (mc >= 0) begin s[21] = 1; s[20:16] = 5'(mc); end
    if (pc >= 0) begin s[29] = 1; s[28:24] = 5'(pc); end
    return s;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic [16:0] m, input logic [23:0] p,
                      input logic w, input logic s, input logic [31:0] d, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    crit = c; mreq = m; preq = p; wr = w; sel = s; wdata = d;
    #1;
    exp = model(c, m, p, mm, pm);
    check32({tag, " status"}, status, exp);
    check32("R11 irq", {31'd0, irq}, {31'd0, exp[10] | exp[21] | exp[29]});
    check32("R2 readback", rdata, s ? pm : mm);
    if (w) begin
      if (s) pm = d & 32'hFFFF_FF00;
      else   mm = d & 32'h0001_FFFF;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values, R10 zero status
    step(4'h0, '0, '0, 0, 0, '0, "R1 R10 idle");
    step(4'h0, '0, '0, 0, 1, '0, "R1 per reset");
    step(4'b0100, '0, '0, 0, 0, '0, "R5 crit bit2 ignored");
    step(4'b1000, '0, '0, 0, 0, '0, "R5 crit code3");
    step(4'b1011, '0, '0, 0, 0, '0, "R5 crit lowest");
    step(4'h0, '0, 24'h000001, 0, 0, '0, "R6 R9 dma hp slot");
    step(4'h0, '0, 24'h400000, 0, 0, '0, "R8 R9 lp slot");
    step(4'h0, '0, 24'h000020, 0, 0, '0, "R4 per5 masked");
    step(4'h0, 17'h00010, '0, 0, 0, '0, "R7 main bit4 ignored");
    step(4'h0, 17'h00001, '0, 0, 0, '0, "R3 main0 masked");
    step(4'h0, 17'h0000E, '0, 0, 0, '0, "R7 main lowest");
    step(4'h0, 17'h00001, '0, 1, 0, 32'h0, "R12 main0 before write");
    step(4'h0, 17'h00001, '0, 0, 0, '0, "R3 R12 main0 after write");
    step(4'h0, '0, 24'h000020, 1, 1, 32'h0, "R12 per before write");
    step(4'h0, '0, 24'h000020, 0, 1, '0, "R4 R8 per5 enabled");
    step(4'h0, '0, 24'h000020, 1, 0, 32'h0000_1000, "R8 gate prep");
    step(4'h0, '0, 24'h000020, 0, 0, '0, "R8 lp slot gated");
    step(4'h0, '0, '0, 1, 0, 32'hFFFF_FFFF, "R2 main all ones");
    step(4'h0, '0, '0, 1, 1, 32'hFFFF_FFFF, "R2 main readback");
    step(4'h0, '0, 24'hFFFFFF, 0, 1, '0, "R2 R4 per readback");
    step(4'h8, 17'h1FFFF, 24'hFFFFFF, 0, 0, '0, "R3 R4 all masked");
    for (int i = 0; i < 3000; i++) begin
      logic w = ($urandom % 8) == 0;
      step(4'($urandom), 17'($urandom & $urandom), 24'($urandom & $urandom & $urandom),
           w, 1'($urandom), $urandom, "R5/R7/R9 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule